// File: doc/BRIEF.md
# Asynchronous Page-Mode Read Sequencer

The sequencer serves a host burst read of one or more 32-bit words from a nonmultiplexed 16-bit asynchronous memory. It drives chip select, address-valid, output enable, a bus-direction indicator and the word address. It reads a page of 16-bit words in a single device access and packs each pair of captured words into one 32-bit host word. A burst of two host words therefore becomes one device access of four 16-bit words when it fits within a device page.

All timing comes from cycle-count inputs measured from the start of each initial access phase. The first word is taken when the access counter reaches the read-access count. The strobes then stay frozen while the remaining words of the page are taken, one every page-interval cycles. After the last word of the phase the counter resumes up to the cycle-time count. This tail portion covers the address hold after chip select is released. A burst that would run over a device page boundary is split. The remaining words are read in a fresh initial access with the full latency. The active-low wait input stalls any latch point while it is low.

Top module: `page_rd_seq`

## Requirements
- R1: After reset and while idle, cs_no, adv_no and oe_no are high, and dir_o, busy_o, done_o and hvalid_o are low.
- R2: Each initial access phase starts with its access counter at 0, counting one per cycle. The first word of the phase is captured in the cycle where the counter equals rd_access_i, which is cycle rd_access_i+1 of the phase.
- R3: Every further word in the same phase is captured max(page_access_i,1) cycles after the previous capture.
- R4: A strobe is asserted (low) while the counter value c satisfies on <= c < off for its own on/off inputs. From the first capture to the last capture of a phase, the counter and all strobes are frozen. With oe_on_i=1 and oe_off_i=rd_access_i+1, oe_no is therefore low for rd_access_i + (k-1)*max(page_access_i,1) cycles in a phase of k words, or 0 cycles when rd_access_i=0.
- R5: addr_o starts at addr_i and increments by one after each captured word. The word captured is the data_i present at that address.
- R6: A phase ends after the word whose address has all low log2(PAGE_WORDS) bits set. If words remain, a new initial access begins at the next address with the counter back at 0, and chip select is deasserted between the two phases.
- R7: After its last capture, a phase continues with the counter at rd_access_i+1 and counting. The phase ends in the cycle where the counter is at least cycle_time_i, so at least one tail cycle always occurs.
- R8: While wait_ni is low in a cycle that would capture a word, no word is captured and the counters, address and state hold.
- R9: Captured words are paired in order. The first word of a pair goes to hdata_o[15:0] and the second to hdata_o[31:16]. hvalid_o pulses for one cycle, one cycle after the second capture of each pair.
- R10: A burst of nhost_i host words reads 2*nhost_i device words. done_o pulses for one cycle, one cycle after the final phase ends. req_i is ignored while busy_o is high and is taken again from the cycle in which done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Burst read request, taken when idle |
| addr_i | input | AW | Start word address |
| nhost_i | input | NW | Number of 32-bit host words (at least 1) |
| rd_access_i | input | TW | Cycles from phase start to first capture |
| page_access_i | input | PW | Cycles between page captures (0 acts as 1) |
| cycle_time_i | input | TW | Counter value that ends a phase |
| cs_on_i | input | TW | Chip-select assert count |
| cs_off_i | input | TW | Chip-select deassert count |
| adv_on_i | input | TW | Address-valid assert count |
| adv_off_i | input | TW | Address-valid deassert count |
| oe_on_i | input | TW | Output-enable assert count; also starts inbound direction |
| oe_off_i | input | TW | Output-enable deassert count |
| wait_ni | input | 1 | Device wait, active low |
| data_i | input | DW | Device read data |
| cs_no | output | 1 | Chip select, active low |
| adv_no | output | 1 | Address valid, active low |
| oe_no | output | 1 | Output enable, active low |
| dir_o | output | 1 | High while the data bus is inbound |
| addr_o | output | AW | Device word address |
| hdata_o | output | 2*DW | Packed host word |
| hvalid_o | output | 1 | Host word valid pulse |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | Burst complete pulse |

## Verification
The assertions assume that the timing inputs stay constant while a burst runs, that nhost_i is at least 1 when a request is taken, and that data_i is valid whenever a capture can happen. The bench sets every timing input before raising req_i and holds it until done_o. It limits nhost_i to non-zero table values. It drives data_i combinationally from addr_o through a fixed address-to-data function, so the read data always matches the address presented. wait_ni only changes on falling clock edges and is released within a bounded number of cycles.

// File: rtl/page_rd_pkg.sv
package page_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_PAGE   = 2'd2,
    ST_TAIL   = 2'd3
  } rd_state_e;
endpackage

// File: rtl/page_rd_timer.sv
module page_rd_timer #(
  parameter int CW = 6,
  parameter int PW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          t_clr_i,
  input  logic          t_inc_i,
  input  logic          pc_load_i,
  input  logic          pc_inc_i,
  output logic [CW-1:0] t_o,
  output logic [PW-1:0] pc_o
);
  logic [CW-1:0] t_q;
  logic [PW-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q <= '0;
    end else if (t_clr_i) begin
      t_q <= '0;
    end else if (t_inc_i && !(&t_q)) begin
      t_q <= t_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (pc_load_i) begin
      pc_q <= PW'(1);
    end else if (pc_inc_i && !(&pc_q)) begin
      pc_q <= pc_q + 1'b1;
    end
  end

  assign t_o  = t_q;
  assign pc_o = pc_q;

  p_clr_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_clr_i |=> (t_q == '0));
endmodule

// File: rtl/page_rd_strobes.sv
module page_rd_strobes #(
  parameter int TW = 5,
  parameter int CW = TW + 1
) (
  input  logic          active_i,
  input  logic [CW-1:0] t_i,
  input  logic [TW-1:0] cs_on_i,
  input  logic [TW-1:0] cs_off_i,
  input  logic [TW-1:0] adv_on_i,
  input  logic [TW-1:0] adv_off_i,
  input  logic [TW-1:0] oe_on_i,
  input  logic [TW-1:0] oe_off_i,
  output logic          cs_no,
  output logic          adv_no,
  output logic          oe_no,
  output logic          dir_o
);
  localparam int NS = 3;

  logic [NS-1:0][TW-1:0] on_w, off_w;
  logic [NS-1:0]         act_w;

  assign on_w  = {oe_on_i,  adv_on_i,  cs_on_i};
  assign off_w = {oe_off_i, adv_off_i, cs_off_i};

  for (genvar i = 0; i < NS; i++) begin : g_win
    assign act_w[i] = active_i && (t_i >= {1'b0, on_w[i]}) && (t_i < {1'b0, off_w[i]});
  end

  assign cs_no  = !act_w[0];
  assign adv_no = !act_w[1];
  assign oe_no  = !act_w[2];
  assign dir_o  = active_i && (t_i >= {1'b0, oe_on_i});
endmodule

// File: rtl/page_rd_pack.sv
module page_rd_pack #(
  parameter int DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            cap_i,
  input  logic [DW-1:0]   din_i,
  output logic [2*DW-1:0] hdata_o,
  output logic            hvalid_o
);
  logic            half_q;
  logic [DW-1:0]   low_q;
  logic [2*DW-1:0] hdata_q;
  logic            hvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q   <= 1'b0;
      low_q    <= '0;
      hdata_q  <= '0;
      hvalid_q <= 1'b0;
    end else begin
      hvalid_q <= 1'b0;
      if (start_i) begin
        half_q <= 1'b0;
      end else if (cap_i) begin
        if (!half_q) begin
          low_q  <= din_i;
          half_q <= 1'b1;
        end else begin
          hdata_q  <= {din_i, low_q};
          hvalid_q <= 1'b1;
          half_q   <= 1'b0;
        end
      end
    end
  end

  assign hdata_o  = hdata_q;
  assign hvalid_o = hvalid_q;

  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hvalid_q |=> !hvalid_q);
  p_valid_after_pair_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && half_q && !start_i) |=> (hvalid_q && hdata_q[DW-1:0] == $past(low_q)));
endmodule

// File: rtl/page_rd_seq.sv
module page_rd_seq
  import page_rd_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int NW         = 4,
  parameter int TW         = 5,
  parameter int PW         = 4,
  parameter int PAGE_WORDS = 4   // power of two, at least 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NW-1:0]   nhost_i,
  input  logic [TW-1:0]   rd_access_i,
  input  logic [PW-1:0]   page_access_i,
  input  logic [TW-1:0]   cycle_time_i,
  input  logic [TW-1:0]   cs_on_i,
  input  logic [TW-1:0]   cs_off_i,
  input  logic [TW-1:0]   adv_on_i,
  input  logic [TW-1:0]   adv_off_i,
  input  logic [TW-1:0]   oe_on_i,
  input  logic [TW-1:0]   oe_off_i,
  input  logic            wait_ni,
  input  logic [DW-1:0]   data_i,
  output logic            cs_no,
  output logic            adv_no,
  output logic            oe_no,
  output logic            dir_o,
  output logic [AW-1:0]   addr_o,
  output logic [2*DW-1:0] hdata_o,
  output logic            hvalid_o,
  output logic            busy_o,
  output logic            done_o
);
  localparam int CW  = TW + 1;
  localparam int RW  = NW + 1;
  localparam int PGB = $clog2(PAGE_WORDS);

  rd_state_e     st_q, st_d;
  logic [AW-1:0] addr_q;
  logic [RW-1:0] rem_q;
  logic          done_q;
  logic [CW-1:0] t_w;
  logic [PW-1:0] pc_w, pg_eff;
  logic          start_w, latch_pt, cap_w, last_w, tail_end;
  logic          t_clr, t_inc, pc_load, pc_inc;

  assign pg_eff   = (page_access_i == '0) ? PW'(1) : page_access_i;
  assign start_w  = (st_q == ST_IDLE) && req_i;
  assign latch_pt = ((st_q == ST_ACCESS) && (t_w == {1'b0, rd_access_i})) ||
                    ((st_q == ST_PAGE) && (pc_w >= pg_eff));
  assign cap_w    = latch_pt && wait_ni;
  assign last_w   = (rem_q == RW'(1)) || (&addr_q[PGB-1:0]);
  assign tail_end = (st_q == ST_TAIL) && (t_w >= {1'b0, cycle_time_i});

  assign t_clr   = start_w || (tail_end && rem_q != '0);
  assign t_inc   = ((st_q == ST_ACCESS) && !latch_pt) || (cap_w && last_w) ||
                   ((st_q == ST_TAIL) && !tail_end);
  assign pc_load = cap_w;
  assign pc_inc  = (st_q == ST_PAGE) && !latch_pt;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_i) st_d = ST_ACCESS;
      ST_ACCESS,
      ST_PAGE:   if (cap_w) st_d = last_w ? ST_TAIL : ST_PAGE;
      ST_TAIL:   if (tail_end) st_d = (rem_q == '0) ? ST_IDLE : ST_ACCESS;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= tail_end && (rem_q == '0);
      if (start_w) begin
        addr_q <= addr_i;
        rem_q  <= {nhost_i, 1'b0};
      end else if (cap_w) begin
        addr_q <= addr_q + 1'b1;
        rem_q  <= rem_q - 1'b1;
      end
    end
  end

  page_rd_timer #(.CW(CW), .PW(PW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .t_clr_i  (t_clr),
    .t_inc_i  (t_inc),
    .pc_load_i(pc_load),
    .pc_inc_i (pc_inc),
    .t_o      (t_w),
    .pc_o     (pc_w)
  );

  page_rd_strobes #(.TW(TW), .CW(CW)) u_strobes (
    .active_i (st_q != ST_IDLE),
    .t_i      (t_w),
    .cs_on_i  (cs_on_i),
    .cs_off_i (cs_off_i),
    .adv_on_i (adv_on_i),
    .adv_off_i(adv_off_i),
    .oe_on_i  (oe_on_i),
    .oe_off_i (oe_off_i),
    .cs_no    (cs_no),
    .adv_no   (adv_no),
    .oe_no    (oe_no),
    .dir_o    (dir_o)
  );

  page_rd_pack #(.DW(DW)) u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .cap_i   (cap_w),
    .din_i   (data_i),
    .hdata_o (hdata_o),
    .hvalid_o(hvalid_o)
  );

  assign addr_o = addr_q;
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;

  p_idle_strobes_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> (cs_no && adv_no && oe_no && !dir_o));
  p_frozen_page_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PAGE && $past(st_q) == ST_PAGE) |-> ($stable(t_w) && $stable({cs_no, adv_no, oe_no, dir_o})));
  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_w && !start_w) |=> (addr_q == $past(addr_q) + 1'b1));
  p_new_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tail_end && rem_q != '0) |=> (st_q == ST_ACCESS && t_w == '0 && cs_no == !(cs_on_i == '0 && cs_off_i != '0)));
  p_wait_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_pt && !wait_ni) |=> ($stable(addr_q) && $stable(rem_q) && $stable(st_q) && $stable(t_w)));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_busy_ignores_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && !cap_w) |=> $stable(addr_q));
endmodule

// File: tb/sim_page_rd_seq.sv
module sim_page_rd_seq;
  localparam int AW = 16, DW = 16, NW = 4, TW = 5, PW = 4, PG = 4;
  localparam int NV = 5;
  // {addr[15:0], nhost[3:0], rd[4:0], pg[3:0], cyc[4:0], phases[2:0]}
  localparam logic [36:0] VEC [NV] = '{
    {16'd0, 4'd2, 5'd3, 4'd1, 5'd6,  3'd1},
    {16'd2, 4'd2, 5'd4, 4'd2, 5'd8,  3'd2},
    {16'd1, 4'd1, 5'd2, 4'd0, 5'd2,  3'd1},
    {16'd7, 4'd3, 5'd5, 4'd3, 5'd20, 3'd3},
    {16'd0, 4'd1, 5'd0, 4'd1, 5'd1,  3'd1}
  };

  logic clk = 0, rst_n = 0, req = 0, wait_n = 1;
  logic [AW-1:0] addr_in = '0;
  logic [NW-1:0] nhost = '0;
  logic [TW-1:0] rd = '0, cyc = '0, cs_on = '0, cs_off = '0, adv_on = '0, adv_off = '0, oe_on = '0, oe_off = '0;
  logic [PW-1:0] pga = '0;
  logic [DW-1:0] data;
  logic cs_n, adv_n, oe_n, dir, hvalid, busy, done;
  logic [AW-1:0] addr_out;
  logic [2*DW-1:0] hdata;

  int checks = 0, errors = 0;
  int got_cyc, got_ph, got_oe, got_n;
  logic [31:0] got_w [16];

  always #2 clk = ~clk;

  function automatic logic [15:0] mem(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  assign data = mem(addr_out);

  page_rd_seq #(.AW(AW), .DW(DW), .NW(NW), .TW(TW), .PW(PW), .PAGE_WORDS(PG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr_in), .nhost_i(nhost),
    .rd_access_i(rd), .page_access_i(pga), .cycle_time_i(cyc),
    .cs_on_i(cs_on), .cs_off_i(cs_off), .adv_on_i(adv_on), .adv_off_i(adv_off),
    .oe_on_i(oe_on), .oe_off_i(oe_off), .wait_ni(wait_n), .data_i(data),
    .cs_no(cs_n), .adv_no(adv_n), .oe_no(oe_n), .dir_o(dir), .addr_o(addr_out),
    .hdata_o(hdata), .hvalid_o(hvalid), .busy_o(busy), .done_o(done));

  task automatic check(input string req_tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
    end
  endtask

  // expected cycles and oe-low cycles, from the requirements
  task automatic model(input int a, input int n, input int r, input int p, input int c,
                       output int cycles, output int oel, output int phases);
    int rem = 2 * n;
    int pe = (p == 0) ? 1 : p;
    cycles = 0; oel = 0; phases = 0;
    while (rem > 0) begin
      int k = PG - (a % PG);
      if (k > rem) k = rem;
      phases++;
      cycles += r + 1 + (k - 1) * pe + ((c - r > 1) ? c - r : 1);
      oel += (r == 0) ? 0 : r + (k - 1) * pe;
      a += k; rem -= k;
    end
  endtask

  task automatic run(input logic [36:0] v, input int wait_cyc, input bit hold_req);
    logic prev_cs = 1'b1;
    int n = 0;
    @(negedge clk);
    addr_in = v[36:21]; nhost = v[20:17]; rd = v[16:12]; pga = v[11:8]; cyc = v[7:3];
    cs_on = 0; cs_off = rd + 1; adv_on = 0; adv_off = 1; oe_on = 1; oe_off = rd + 1;
    req = 1;
    if (wait_cyc > 0) wait_n = 0;
    @(posedge clk);
    @(negedge clk);
    if (!hold_req) req = 0;
    got_cyc = 0; got_ph = 0; got_oe = 0; got_n = 0;
    forever begin
      if (prev_cs && !cs_n) got_ph++;
      if (!oe_n) got_oe++;
      prev_cs = cs_n;
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == wait_cyc) wait_n = 1;
      if (hvalid && got_n < 16) begin got_w[got_n] = hdata; got_n++; end
      if (done || n > 3000) break;
    end
    got_cyc = n;
    req = 0;
  endtask

  task automatic score(input logic [36:0] v, input int extra);
    int ec, eo, ep;
    model(int'(v[36:21]), int'(v[20:17]), int'(v[16:12]), int'(v[11:8]), int'(v[7:3]), ec, eo, ep);
    check("R2/R3/R7 burst length", got_cyc, ec + extra);
    check("R6 phase count", got_ph, ep);
    check("R6 phase count table", got_ph, int'(v[2:0]));
    if (extra == 0) check("R4 oe low cycles", got_oe, eo);
    check("R10 host word count", got_n, int'(v[20:17]));
    for (int j = 0; j < int'(v[20:17]) && j < got_n; j++) begin
      logic [15:0] a0 = v[36:21] + 16'(2 * j);
      check("R5/R9 packed word", got_w[j], {mem(a0 + 16'd1), mem(a0)});
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cs in reset", cs_n, 1);
    check("R1 oe in reset", oe_n, 1);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle strobes", {cs_n, adv_n, oe_n, dir}, 4'b1110);
    check("R1 idle flags", {busy, done, hvalid}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i], 0, 1'b0);
      score(VEC[i], 0);
    end

    // R8: wait low through cycles 1..6, latch point at cycle 4 stalls 3 cycles
    run(VEC[0], 6, 1'b0);
    score(VEC[0], 3);

    // R10: request held high through the burst is ignored while busy
    run(VEC[1], 0, 1'b1);
    score(VEC[1], 0);
    @(negedge clk);
    check("R10 done single cycle", done, 0);
    check("R10 no restart after drop", busy, 0);
    check("R1 idle after burst", {cs_n, adv_n, oe_n}, 3'b111);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule